// File: doc/BRIEF.md
# Strobed-Address 4-to-16 Line Decoder and Demultiplexer

This block turns a 4-bit select address into one active line out of sixteen. The address first passes through a holding stage that is driven by a strobe. While the strobe is high, the stage passes the address straight through. While the strobe is low, the decoder keeps using the address that was present in the last cycle the strobe was high.

An active-low enable gates every output and is never held by the strobe. Because it acts on the output at all times, it can carry a serial data stream, which makes the block a one-to-sixteen demultiplexer steered by the address. It can also serve as a chip select, so that several decoders can share one address bus.

A compile-time parameter picks the output polarity. In the true variant the selected line is high and all others are low. In the inverted variant the selected line is low and all others are high. Following the FPGA house style, the output vector is registered: it reflects the inputs sampled at the previous rising clock edge. Reset is synchronous and active high.

Top module: `latdec_top`

## Requirements
- R1: A synchronous reset clears the held address to 0 and, one edge later, drives every output to its inactive level. After reset, the held address stays 0 until the strobe is raised.
- R2: When `strobe` is 1 at a clock edge, the output after that edge decodes the `sel_addr` sampled at that same edge (transparent path).
- R3: When `strobe` is 0 at a clock edge, the output decodes the address from the last edge at which `strobe` was 1, and changes on `sel_addr` have no effect on it.
- R4: Address value k, read as binary with `sel_addr[3]` as the most significant bit, selects output bit `y_out[k]`, so 0 selects bit 0 and 15 selects bit 15.
- R5: When `en_n` is 0 at an edge, exactly one output is at the active level after that edge: the addressed one.
- R6: When `en_n` is 1 at an edge, every output is at its inactive level after that edge, whatever the address.
- R7: `en_n` is not held by the strobe. Each change on it reaches the outputs after the next edge even while `strobe` is 0, so a bit stream on `en_n` appears on the addressed line.
- R8: With `INVERT`=0 the active level is 1 and the inactive level is 0. With `INVERT`=1 the active level is 0 and the inactive level is 1.
- R9: At most one output is ever active. Two decoders that share the address and strobe but have complementary enables show exactly one active line across their 32 outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_addr | input | ADDR_W (4) | Select address, with bit 3 as the most significant bit |
| strobe | input | 1 | 1 passes the address through; 0 keeps the held address |
| en_n | input | 1 | Active-low enable; also the demultiplexer data input and chip select |
| y_out | output | 2**ADDR_W (16) | Registered decoded outputs; polarity set by `INVERT` |

## Verification
The assertions assume that every input has a known 0 or 1 value at each rising edge and that reset is held for at least one edge before any check depends on the held address. The stimulus therefore changes inputs only one time unit after the falling edge, starts under reset, and never leaves an input undriven. The hold check also assumes the enable stays low across the two edges it compares. The stimulus keeps the enable low through the address sweep with the strobe low, so that the output should not move while the address changes.

// File: rtl/latdec_pkg.sv
package latdec_pkg;
  localparam int unsigned DEF_ADDR_W = 4;

  // number of decoded lines for an address width
  function automatic int unsigned lines_for(input int unsigned aw);
    return 1 << aw;
  endfunction
endpackage

// File: rtl/latdec_addr_hold.sv
module latdec_addr_hold #(
  parameter int unsigned ADDR_W = latdec_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_eff
);
  logic [ADDR_W-1:0] addr_q;

  // capture while the strobe is open; keep the last value once it closes
  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (strobe) addr_q <= addr_in;
  end

  // transparent path while strobe is high
  assign addr_eff = strobe ? addr_in : addr_q;
endmodule

// File: rtl/latdec_onehot.sv
module latdec_onehot #(
  parameter int unsigned ADDR_W = latdec_pkg::DEF_ADDR_W,
  localparam int unsigned OUT_W = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [OUT_W-1:0]  sel
);
  for (genvar i = 0; i < OUT_W; i++) begin : g_line
    assign sel[i] = (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/latdec_out_stage.sv
module latdec_out_stage #(
  parameter int unsigned OUT_W  = 16,
  parameter bit          INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_n,
  input  logic [OUT_W-1:0] sel,
  output logic [OUT_W-1:0] y
);
  logic [OUT_W-1:0] idle_lvl;
  logic [OUT_W-1:0] act_lvl;

  if (INVERT) begin : g_inv
    assign idle_lvl = '1;
    assign act_lvl  = ~sel;
  end else begin : g_true
    assign idle_lvl = '0;
    assign act_lvl  = sel;
  end

  // the enable gates every edge, independent of the address strobe
  always_ff @(posedge clk) begin
    if (rst)       y <= idle_lvl;
    else if (en_n) y <= idle_lvl;
    else           y <= act_lvl;
  end
endmodule

// File: rtl/latdec_top.sv
module latdec_top #(
  parameter int unsigned ADDR_W = latdec_pkg::DEF_ADDR_W,
  parameter bit          INVERT = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        sel_addr,
  input  logic                     strobe,
  input  logic                     en_n,
  output logic [(1<<ADDR_W)-1:0]   y_out
);
  localparam int unsigned OUT_W = latdec_pkg::lines_for(ADDR_W);

  logic [ADDR_W-1:0] addr_eff;
  logic [OUT_W-1:0]  sel_vec;

  latdec_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst(rst), .strobe(strobe),
    .addr_in(sel_addr), .addr_eff(addr_eff)
  );

  latdec_onehot #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr_eff), .sel(sel_vec)
  );

  latdec_out_stage #(.OUT_W(OUT_W), .INVERT(INVERT)) u_out (
    .clk(clk), .rst(rst), .en_n(en_n), .sel(sel_vec), .y(y_out)
  );
endmodule

// File: rtl/latdec_chk.sv
module latdec_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter bit          INVERT = 1'b0
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      sel_addr,
  input logic                   strobe,
  input logic                   en_n,
  input logic [(1<<ADDR_W)-1:0] y_out
);
  localparam int unsigned OUT_W = 1 << ADDR_W;
  localparam logic [OUT_W-1:0] IDLE = INVERT ? {OUT_W{1'b1}} : {OUT_W{1'b0}};

  logic [OUT_W-1:0] act;
  assign act = INVERT ? ~y_out : y_out;

  // R1 and R8: the edge after a reset edge leaves all lines idle
  p_reset_idle_r1: assert property (@(posedge clk) $past(rst) |-> (y_out == IDLE));

  // R9: never more than one active line
  p_at_most_one_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(act) <= 1);

  // R6: disabled means all idle
  p_disabled_idle_r6: assert property (@(posedge clk) disable iff (rst)
    en_n |=> (y_out == IDLE));

  // R5: enabled means exactly one active line
  p_enabled_one_r5: assert property (@(posedge clk) disable iff (rst)
    !en_n |=> ($countones(act) == 1));

  // R2 and R4: transparent path decodes the address of the same edge
  p_transparent_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe && !en_n) |=> (act == (OUT_W'(1) << $past(sel_addr))));

  // R3: strobe closed and enabled on two edges in a row keeps the output still
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !en_n && !$past(strobe) && !$past(en_n) && !$past(rst)) |=> $stable(y_out));
endmodule

bind latdec_top latdec_chk #(.ADDR_W(ADDR_W), .INVERT(INVERT)) u_chk (
  .clk(clk), .rst(rst), .sel_addr(sel_addr), .strobe(strobe),
  .en_n(en_n), .y_out(y_out)
);

// File: tb/tb_latdec_top.sv
module tb_latdec_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = 4'd0;
  logic        stb = 1'b0;
  logic        en_n = 1'b1;
  logic        en_b = 1'b1;
  logic [15:0] ya, yb, yi;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  bit    cascade  = 1'b0;
  string cur_req  = "R1";

  // reference model state
  int          held;
  logic [15:0] exp_a, exp_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  // true-polarity device, cascade partner and inverted device
  latdec_top #(.ADDR_W(4), .INVERT(1'b0)) dut (
    .clk(clk), .rst(rst), .sel_addr(addr), .strobe(stb), .en_n(en_n), .y_out(ya));
  latdec_top #(.ADDR_W(4), .INVERT(1'b0)) dut_b (
    .clk(clk), .rst(rst), .sel_addr(addr), .strobe(stb), .en_n(en_b), .y_out(yb));
  latdec_top #(.ADDR_W(4), .INVERT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .sel_addr(addr), .strobe(stb), .en_n(en_n), .y_out(yi));

  always @(posedge clk) begin
    int eff;
    if (rst) begin
      held  = 0;
      exp_a = 16'h0000;
      exp_b = 16'h0000;
    end else begin
      eff = stb ? int'(addr) : held;
      if (stb) held = int'(addr);
      exp_a = en_n ? 16'h0000 : (16'h0001 << eff);
      exp_b = en_b ? 16'h0000 : (16'h0001 << eff);
    end
  end

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h at t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    cycles++;
    check(cur_req, "true device",    ya, exp_a);
    check(cur_req, "partner device", yb, exp_b);
    check("R8",    "inverted device", yi, ~exp_a);
    n_checks++;
    if ($countones(ya) > 1) begin
      n_fail++;
      $display("FAIL R9 more than one active: got %h expected at most one bit", ya);
    end
    if (cascade) begin
      n_checks++;
      if ($countones({ya, yb}) != 1) begin
        n_fail++;
        $display("FAIL R9 cascade: got %h_%h expected exactly one active of 32", yb, ya);
      end
    end
    if (cycles > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic drive(int a, bit s, bit e, bit eb);
    @(negedge clk);
    #1;
    addr = 4'(a);
    stb  = s;
    en_n = e;
    en_b = eb;
  endtask

  initial begin
    // R1: reset state, all idle, inverted device all high (R8)
    cur_req = "R1";
    repeat (3) drive(0, 0, 1, 1);
    rst = 1'b0;
    drive(7, 0, 0, 1);
    drive(7, 0, 0, 1); // held address still 0 after reset
    // R2 / R4 / R5: transparent sweep of every address
    cur_req = "R4";
    for (int k = 0; k < 16; k++) drive(k, 1, 0, 1);
    cur_req = "R2";
    for (int k = 15; k >= 0; k -= 3) drive(k, 1, 0, 1);
    // R6: disabled, all addresses
    cur_req = "R6";
    for (int k = 0; k < 16; k++) drive(k, k[0], 1, 1);
    // R3: capture 9, then move the address with the strobe closed
    cur_req = "R3";
    drive(9, 1, 0, 1);
    for (int k = 0; k < 16; k++) drive(k, 0, 0, 1);
    // R7: data stream on the enable while the strobe stays closed
    cur_req = "R7";
    for (int k = 0; k < 12; k++) drive(k, 0, (k % 3) == 1, 1);
    drive(12, 1, 0, 1);
    for (int k = 0; k < 8; k++) drive(3, 0, k[1] ^ k[0], 1);
    // R9: two-device cascade with complementary chip selects
    cur_req = "R9";
    for (int k = 0; k < 20; k++) begin
      bit e = ((k * 5) % 7) > 3;
      drive(k % 16, (k % 4) != 0, e, ~e);
      cascade = 1'b1;
    end
    drive(0, 0, 1, 1);
    cascade = 1'b0;
    // R1 again: reset in the middle of an enabled hold
    cur_req = "R1";
    drive(5, 1, 0, 1);
    rst = 1'b1;
    drive(5, 0, 0, 1);
    drive(5, 0, 0, 1);
    rst = 1'b0;
    drive(11, 0, 0, 1);
    drive(11, 0, 0, 1);
    drive(11, 0, 0, 1);
    summary();
  end
endmodule